// File: doc/BRIEF.md
# Pipeline Exception Controller

This unit watches a five-stage in-order pipeline for three kinds of trap: an undefined opcode decoded in the decode stage, an arithmetic overflow produced in the execute stage, and an external interrupt request. When one is taken, it captures the address of the trapping instruction plus four, records a 5-bit cause code, and redirects fetch to a handler. In the same cycle it zeroes the control fields that go into the pipeline registers holding the trapping instruction and every younger one. If the trap is in the execute stage, it also blocks that instruction's register write-back.

Only the oldest trapping instruction is serviced, so exceptions stay precise. The handler target is either one fixed entry point or a per-cause entry picked from a table of 32-byte slots. A small status register holds an interrupt enable, the vectored-mode selector and a "handler active" flag. A read port returns status, cause or saved PC for a move-from instruction. A return instruction in decode sends fetch back to the saved PC.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the saved PC, cause and status read as zero, and no redirect, flush or write-inhibit is asserted while no trap input or return is present.
- R2: An undefined opcode in decode (`id_undef`) is taken with cause code 10. The saved PC becomes `id_pc`+4. `flush_ifid` and `flush_idex` are asserted, while `flush_exmem` and `ex_wr_inhibit` stay low.
- R3: An overflow in execute (`ex_ovf`) is taken with cause code 12. The saved PC becomes `ex_pc`+4. All three flushes and `ex_wr_inhibit` are asserted in the same cycle as the redirect.
- R4: An interrupt request (`irq`) is taken only when the enable bit is 1 and the handler-active bit is 0. It is charged to the instruction in execute, with cause code 0, saved PC `ex_pc`+4, and the same flushes and write-inhibit as R3.
- R5: When several traps are present in one cycle, the oldest is taken: interrupt first, then overflow, then undefined opcode.
- R6: With the vectored bit at 0, `redirect_pc` on a trap is 0x80000180.
- R7: With the vectored bit at 1, `redirect_pc` is 0xC0000000 plus 32 times a slot index. The index is 0 for undefined opcode, 1 for overflow and 2 for interrupt.
- R8: A taken trap sets the handler-active bit. A return (`id_eret`) with no trap taken in that cycle redirects to the saved PC, asserts only `flush_ifid` and clears the handler-active bit. A trap in the same cycle overrides the return.
- R9: `rd_sel` 0 reads status: bit 0 enable, bit 1 vectored, bit 2 handler-active. `rd_sel` 1 reads cause, with the code in bits [6:2]. `rd_sel` 2 reads the saved PC and `rd_sel` 3 reads zero. All other bits read 0.
- R10: `st_we` loads the enable bit from `st_wdata[0]` and the vectored bit from `st_wdata[1]` at the next edge. The handler-active bit cannot be written this way.
- R11: In a cycle with no trap taken, the saved PC and cause keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | 32 | Address of the decode-stage instruction |
| id_eret | input | 1 | Decode stage holds a return-from-trap |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| irq | input | 1 | External interrupt request |
| st_we | input | 1 | Status write strobe |
| st_wdata | input | 32 | Status write data |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 32 | Selected register value |
| redirect | output | 1 | Load fetch PC from `redirect_pc` |
| redirect_pc | output | 32 | New fetch address |
| flush_ifid | output | 1 | Zero control entering IF/ID |
| flush_idex | output | 1 | Zero control entering ID/EX |
| flush_exmem | output | 1 | Zero control entering EX/MEM |
| ex_wr_inhibit | output | 1 | Block register write of the execute-stage instruction |

## Verification
The assertions assume that the trap and return flags are meaningful in every cycle after reset. They also assume that a flushed instruction never raises a flag again, because the pipeline is expected to drop what the flushes remove. The checks that the saved PC holds and the handler-active bit sets rely on the decode-stage flush being raised only by a taken trap. The stimulus sets every flag independently in each cycle. Overlapping traps, a return during a trap, and interrupts while masked therefore occur freely, and the bench model predicts each outcome from the priority and gating rules.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        EK_NONE  = 2'd0,
        EK_UNDEF = 2'd1,
        EK_OVF   = 2'd2,
        EK_IRQ   = 2'd3
    } exc_kind_e;

    localparam logic [CODE_W-1:0] CODE_IRQ   = 5'd0;
    localparam logic [CODE_W-1:0] CODE_UNDEF = 5'd10;
    localparam logic [CODE_W-1:0] CODE_OVF   = 5'd12;

    typedef struct packed {
        logic [XLEN-1:0]   epc;
        logic [CODE_W-1:0] code;
        logic              ie;
        logic              vec;
        logic              exl;
    } ctl_state_t;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_undef,
    input  logic       req_ovf,
    input  logic       req_irq,
    output exc_kind_e  kind,
    output logic [2:0] grant
);
    always_comb begin
        grant = 3'b000;
        kind  = EK_NONE;
        if (req_irq) begin
            grant = 3'b100;
            kind  = EK_IRQ;
        end else if (req_ovf) begin
            grant = 3'b010;
            kind  = EK_OVF;
        end else if (req_undef) begin
            grant = 3'b001;
            kind  = EK_UNDEF;
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    grant_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_irq |-> (kind == EK_IRQ));
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] FIXED_BASE  = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
    parameter int              SLOT_LOG2   = 5
) (
    input  exc_kind_e        kind,
    input  logic             vec_mode,
    output logic [XLEN-1:0]  target
);
    localparam int IDX_W = 2;

    logic [IDX_W-1:0] slot;

    always_comb begin
        case (kind)
            EK_OVF:  slot = 2'd1;
            EK_IRQ:  slot = 2'd2;
            default: slot = 2'd0;
        endcase
        if (vec_mode)
            target = VEC_BASE + (XLEN'(slot) << SLOT_LOG2);
        else
            target = FIXED_BASE;
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] FIXED_BASE = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
    parameter int              SLOT_LOG2  = 5,
    parameter int              INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            id_eret,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            irq,
    input  logic            st_we,
    input  logic [XLEN-1:0] st_wdata,
    input  logic [1:0]      rd_sel,
    output logic [XLEN-1:0] rd_data,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            flush_ifid,
    output logic            flush_idex,
    output logic            flush_exmem,
    output logic            ex_wr_inhibit
);
    localparam int CODE_LSB = 2;
    localparam int PAD_W    = XLEN - CODE_W - CODE_LSB;

    ctl_state_t      st_q, st_d;
    exc_kind_e       kind;
    logic [2:0]      grant;
    logic            irq_req;
    logic            take;
    logic            late;
    logic [XLEN-1:0] fault_pc;
    logic [XLEN-1:0] target;

    assign irq_req = irq && st_q.ie && !st_q.exl;

    exc_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_undef (id_undef),
        .req_ovf   (ex_ovf),
        .req_irq   (irq_req),
        .kind      (kind),
        .grant     (grant)
    );

    exc_vector #(
        .FIXED_BASE (FIXED_BASE),
        .VEC_BASE   (VEC_BASE),
        .SLOT_LOG2  (SLOT_LOG2)
    ) u_vec (
        .kind     (kind),
        .vec_mode (st_q.vec),
        .target   (target)
    );

    always_comb begin
        take     = (grant != 3'b000);
        late     = grant[2] || grant[1];
        fault_pc = late ? ex_pc : id_pc;

        st_d = st_q;
        if (take) begin
            st_d.epc = fault_pc + XLEN'(INSN_BYTES);
            case (kind)
                EK_OVF:  st_d.code = CODE_OVF;
                EK_IRQ:  st_d.code = CODE_IRQ;
                default: st_d.code = CODE_UNDEF;
            endcase
            st_d.exl = 1'b1;
        end else if (id_eret) begin
            st_d.exl = 1'b0;
        end
        if (st_we) begin
            st_d.ie  = st_wdata[0];
            st_d.vec = st_wdata[1];
        end

        redirect      = take || id_eret;
        redirect_pc   = take ? target : st_q.epc;
        flush_ifid    = redirect;
        flush_idex    = take;
        flush_exmem   = late;
        ex_wr_inhibit = late;

        case (rd_sel)
            2'd0:    rd_data = {{(XLEN-3){1'b0}}, st_q.exl, st_q.vec, st_q.ie};
            2'd1:    rd_data = {{PAD_W{1'b0}}, st_q.code, {CODE_LSB{1'b0}}};
            2'd2:    rd_data = st_q.epc;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R3
    inhibit_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_wr_inhibit |-> (flush_exmem && flush_idex && flush_ifid && redirect));

    // R4
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && st_q.exl && !ex_ovf && !id_undef && !id_eret) |-> !redirect);

    // R8
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_idex |=> st_q.exl);

    // R11
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_idex |=> ($stable(st_q.epc) && $stable(st_q.code)));

    // R8
    eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_eret && !flush_idex) |-> (redirect_pc == st_q.epc && !flush_exmem));
endmodule

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_undef = 1'b0, id_eret = 1'b0, ex_ovf = 1'b0, irq = 1'b0, st_we = 1'b0;
    logic [31:0] id_pc = '0, ex_pc = '0, st_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data, redirect_pc;
    logic        redirect, flush_ifid, flush_idex, flush_exmem, ex_wr_inhibit;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_epc = '0;
    logic [4:0]  m_code = '0;
    logic        m_ie = 1'b0, m_vec = 1'b0, m_exl = 1'b0;

    always #2 clk = ~clk;

    exc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_undef(id_undef), .id_pc(id_pc), .id_eret(id_eret),
        .ex_ovf(ex_ovf), .ex_pc(ex_pc), .irq(irq),
        .st_we(st_we), .st_wdata(st_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .redirect(redirect), .redirect_pc(redirect_pc),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex),
        .flush_exmem(flush_exmem), .ex_wr_inhibit(ex_wr_inhibit)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // 0 none, 1 undef, 2 ovf, 3 irq
    function automatic int exp_kind(input logic u, input logic o, input logic i);
        if (i && m_ie && !m_exl) return 3;
        if (o) return 2;
        if (u) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] exp_target(input int k);
        if (!m_vec) return 32'h8000_0180;
        return 32'hC000_0000 + 32'(k - 1) * 32;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: return {29'd0, m_exl, m_vec, m_ie};
            2'd1: return {25'd0, m_code, 2'b00};
            2'd2: return m_epc;
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic u, input logic [31:0] upc, input logic o, input logic [31:0] opc,
                        input logic i, input logic er, input logic we, input logic [31:0] wd,
                        input logic [1:0] sel);
        int k;
        string rq;
        @(posedge clk);
        #1;
        id_undef = u; id_pc = upc; ex_ovf = o; ex_pc = opc; irq = i;
        id_eret = er; st_we = we; st_wdata = wd; rd_sel = sel;
        @(negedge clk);
        k = exp_kind(u, o, i);
        rq = (k == 3) ? "R4" : (k == 2) ? "R3" : (k == 1) ? "R2" : (er ? "R8" : "R11");
        if (k != 0 && (u + o + i) > 1) rq = "R5";
        chk(rq, "redirect", {31'd0, redirect}, {31'd0, (k != 0) || er});
        if (k != 0)
            chk(m_vec ? "R7" : "R6", "redirect_pc", redirect_pc, exp_target(k));
        else if (er)
            chk("R8", "redirect_pc", redirect_pc, m_epc);
        chk(rq, "flush_ifid", {31'd0, flush_ifid}, {31'd0, (k != 0) || er});
        chk(rq, "flush_idex", {31'd0, flush_idex}, {31'd0, k != 0});
        chk(rq, "flush_exmem", {31'd0, flush_exmem}, {31'd0, k >= 2});
        chk(rq, "ex_wr_inhibit", {31'd0, ex_wr_inhibit}, {31'd0, k >= 2});
        chk("R9", "rd_data", rd_data, exp_read(sel));
        if (k != 0) begin
            m_epc  = ((k == 1) ? upc : opc) + 32'd4;
            m_code = (k == 3) ? 5'd0 : (k == 2) ? 5'd12 : 5'd10;
            m_exl  = 1'b1;
        end else if (er) begin
            m_exl = 1'b0;
        end
        if (we) begin
            m_ie  = wd[0];
            m_vec = wd[1];
        end
    endtask

    task automatic read_all(input string req);
        for (int s = 0; s < 4; s++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 2'(s));
            chk(req, "readback", rd_data, exp_read(2'(s)));
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        read_all("R1");
        // R2 fixed target (R6)
        step(1, 32'h0000_0100, 0, 0, 0, 0, 0, 0, 2'd0);
        read_all("R2");
        // R8: return then R10: enable irq + vectored mode, exl write ignored
        step(0, 0, 0, 0, 0, 1, 1, 32'h0000_0007, 2'd2);
        read_all("R10");
        // R5: all three together, vectored R7
        step(1, 32'h40, 1, 32'h3C, 1, 0, 0, 0, 2'd1);
        read_all("R5");
        // R4: irq masked while handler active, ovf still taken (R3)
        step(0, 0, 1, 32'h0000_0200, 1, 0, 0, 0, 2'd1);
        step(0, 0, 0, 0, 1, 0, 0, 0, 2'd0);
        // R8: trap overrides return
        step(1, 32'h0000_0300, 0, 0, 0, 1, 0, 0, 2'd2);
        step(0, 0, 0, 0, 0, 1, 0, 0, 2'd0);
        // R11: idle hold
        read_all("R11");
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 5) == 0, {$urandom} & 32'hFFFF_FFFC,
                 ($urandom % 6) == 0, {$urandom} & 32'hFFFF_FFFC,
                 ($urandom % 6) == 0, ($urandom % 7) == 0,
                 ($urandom % 10) == 0, $urandom, 2'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule